// File: doc/BRIEF.md
# Interval Timer with Paired Interrupt Requests

This block is a down-counting interval timer for a processor subsystem. Software programs a reload value and, while the timer is stopped, an optional starting count. Setting the run bit then starts the counter, which steps down by one on every clock. When it reaches zero, the timer does three things. It drives a one-cycle pulse on an external expiry pin. It raises two interrupt requests, one meant for a high-priority line and one for a low-priority line. It also reloads the counter from the reload register.

The two requests are held in sticky pending bits until software clears them by writing ones. Each request is forwarded to its output only when its own enable bit is set. All state comes out of reset stopped and masked. A plain single-cycle write port and a combinational read port give access to the registers. Word offsets: 0 control (bit 0 run), 1 reload, 2 count, 3 pending, 4 enable mask.

Top module: `ivtimer_top`

## Requirements
- R1: After reset the run bit, count, reload, pending bits and mask bits are all zero, and `irq_hi`, `irq_lo` and `expire` are low.
- R2: While the run bit (offset 0, bit 0) is set and the count is nonzero, the count drops by exactly one per clock. While the run bit is clear, the count holds.
- R3: In any cycle where the run bit is set and the count is zero, `expire` is high, and on the next clock the count takes the reload value (offset 1). With the run bit clear, a zero count produces no pulse.
- R4: While running, successive `expire` pulses are reload+1 clock cycles apart. A reload of zero gives a pulse every cycle.
- R5: A write to the count register (offset 2) loads the value only while the run bit is clear. While running, the write is ignored and counting continues.
- R6: Every expiry sets both pending bits in the pending register (offset 3): bit 0 for the high-priority request and bit 1 for the low-priority request.
- R7: Writing a one to a pending bit clears it, and writing a zero leaves it unchanged. A pending bit that is not cleared stays set across later expiries. If an expiry and a clear hit the same cycle, the bit stays set.
- R8: `irq_hi` equals pending bit 0 AND mask bit 0, and `irq_lo` equals pending bit 1 AND mask bit 1 (mask register at offset 4).
- R9: Reading offsets 0 to 4 returns the stored values, with unused bits as zero. Reading any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register word offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_hi | output | 1 | High-priority interrupt request, masked |
| irq_lo | output | 1 | Low-priority interrupt request, masked |
| expire | output | 1 | One-cycle pulse in each cycle the running count is zero |

## Verification
The assertions assume that `wr_en` is a clean single-cycle strobe, with `addr` and `wdata` valid in the same cycle, and that reset is held for at least one clock before the first write. The bench changes every input only on the falling clock edge, and each write raises `wr_en` for exactly one cycle. It lowers reset only after several clocks. As a result, no write ever overlaps reset and no input changes near the sampling edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned OFF_CTRL   = 0;
  localparam int unsigned OFF_RELOAD = 1;
  localparam int unsigned OFF_COUNT  = 2;
  localparam int unsigned OFF_PEND   = 3;
  localparam int unsigned OFF_MASK   = 4;
  localparam int unsigned NUM_REQ    = 2;
  localparam int unsigned REQ_HI     = 0;
  localparam int unsigned REQ_LO     = 1;
endpackage

// File: rtl/ivt_regfile.sv
module ivt_regfile import ivt_pkg::*; #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      cnt_i,
  input  logic [NUM_REQ-1:0] pend_i,
  output logic              run_o,
  output logic [W-1:0]      reload_o,
  output logic [NUM_REQ-1:0] mask_o,
  output logic              cnt_wr_o,
  output logic [NUM_REQ-1:0] clr_o
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  logic              run_q;
  logic [W-1:0]      reload_q;
  logic [NUM_REQ-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      reload_q <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      if (hit(addr, OFF_CTRL))   run_q    <= wdata[0];
      if (hit(addr, OFF_RELOAD)) reload_q <= wdata;
      if (hit(addr, OFF_MASK))   mask_q   <= wdata[NUM_REQ-1:0];
    end
  end

  assign cnt_wr_o = wr_en && hit(addr, OFF_COUNT);
  assign clr_o    = (wr_en && hit(addr, OFF_PEND)) ? wdata[NUM_REQ-1:0] : '0;
  assign run_o    = run_q;
  assign reload_o = reload_q;
  assign mask_o   = mask_q;

  always_comb begin
    rdata = '0;
    if (hit(addr, OFF_CTRL))   rdata[0] = run_q;
    if (hit(addr, OFF_RELOAD)) rdata = reload_q;
    if (hit(addr, OFF_COUNT))  rdata = cnt_i;
    if (hit(addr, OFF_PEND))   rdata[NUM_REQ-1:0] = pend_i;
    if (hit(addr, OFF_MASK))   rdata[NUM_REQ-1:0] = mask_q;
  end

  // R9
  reload_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit(addr, OFF_RELOAD)) |=> (reload_o == $past(wdata)));
endmodule

// File: rtl/ivt_down_counter.sv
module ivt_down_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  function automatic logic at_zero(input logic [W-1:0] c);
    return c == '0;
  endfunction

  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [W-1:0] p);
    return at_zero(c) ? p : c - W'(1);
  endfunction

  logic [W-1:0] cnt_q;
  logic         load_ok;

  assign load_ok = load_i && !run_i;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (run_i)   cnt_q <= step(cnt_q, reload_i);
    else if (load_ok) cnt_q <= load_val_i;
  end

  assign cnt_o    = cnt_q;
  assign expire_o = run_i && at_zero(cnt_q);

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));
  // R3
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(reload_i)));
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && reload_i != '0 && $stable(run_i)) |=> !expire_o);
endmodule

// File: rtl/ivt_irq_latch.sv
module ivt_irq_latch import ivt_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic [NUM_REQ-1:0] clr_i,
  input  logic [NUM_REQ-1:0] mask_i,
  output logic [NUM_REQ-1:0] pend_o,
  output logic [NUM_REQ-1:0] irq_o
);
  logic [NUM_REQ-1:0] pend_q;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= (pend_q[g] && !clr_i[g]) || set_i;
    end
    assign irq_o[g] = pend_q[g] && mask_i[g];

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i) |=> !pend_q[g]);
  end

  assign pend_o = pend_q;

  // R6
  both_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (pend_q == '1));
endmodule

// File: rtl/ivtimer_top.sv
module ivtimer_top import ivt_pkg::*; #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq_hi,
  output logic              irq_lo,
  output logic              expire
);
  logic               run_w;
  logic [W-1:0]       reload_w;
  logic [W-1:0]       cnt_w;
  logic [NUM_REQ-1:0] mask_w;
  logic [NUM_REQ-1:0] pend_w;
  logic [NUM_REQ-1:0] clr_w;
  logic [NUM_REQ-1:0] irq_w;
  logic               cnt_wr_w;
  logic               expire_w;

  ivt_regfile #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_i(cnt_w), .pend_i(pend_w), .run_o(run_w),
    .reload_o(reload_w), .mask_o(mask_w), .cnt_wr_o(cnt_wr_w), .clr_o(clr_w)
  );

  ivt_down_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .load_i(cnt_wr_w),
    .load_val_i(wdata), .reload_i(reload_w), .cnt_o(cnt_w), .expire_o(expire_w)
  );

  ivt_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(expire_w), .clr_i(clr_w),
    .mask_i(mask_w), .pend_o(pend_w), .irq_o(irq_w)
  );

  assign irq_hi = irq_w[REQ_HI];
  assign irq_lo = irq_w[REQ_LO];
  assign expire = expire_w;

  // R5
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_w && run_w && cnt_w != '0) |=> (cnt_w == $past(cnt_w) - W'(1)));
endmodule

// File: tb/ivtimer_top_bench.sv
module ivtimer_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_hi, irq_lo, expire;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  bit          done = 0;

  ivtimer_top u_ivtimer_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_hi(irq_hi), .irq_lo(irq_lo), .expire(expire)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_pulse(output int at);
    at = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (expire) begin at = cyc; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 reg", v, 0);
    end
    check("R1 irq_hi", 32'(irq_hi), 0);
    check("R1 irq_lo", 32'(irq_lo), 0);
    check("R1/R3 expire idle at zero", 32'(expire), 0);
    rd(3'd7, v); check("R9 unmapped", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(3'd2, 32'd5);
    rd(3'd2, v); check("R5 load idle", v, 5);
    repeat (3) @(negedge clk);
    rd(3'd2, v); check("R2 hold idle", v, 5);
    wr(3'd0, 32'd1);
    rd(3'd0, v); check("R9 ctrl read", v, 1);
    rd(3'd2, v); check("R2 start", v, 5);
    repeat (2) @(negedge clk);
    rd(3'd2, v); check("R2 decrement", v, 3);
    wr(3'd2, 32'd100);
    rd(3'd2, v); check("R5 ignored running", v, 2);
  endtask

  task automatic t_interval();
    logic [31:0] v;
    int t1, t2;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd4);
    rd(3'd1, v); check("R9 reload read", v, 4);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd3);
    wr(3'd0, 32'd1);
    wait_pulse(t1);
    rd(3'd2, v); check("R3 count zero at pulse", v, 0);
    @(negedge clk);
    rd(3'd2, v); check("R3 reload after pulse", v, 4);
    check("R3 pulse one cycle", 32'(expire), 0);
    rd(3'd3, v); check("R6 both pending", v, 3);
    check("R8 masked hi", 32'(irq_hi), 0);
    check("R8 masked lo", 32'(irq_lo), 0);
    wait_pulse(t2);
    check("R4 interval", 32'(t2 - t1), 5);
    wr(3'd0, 32'd0);
    rd(3'd3, v); check("R7 sticky across expiry", v, 3);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    wr(3'd4, 32'd1);
    check("R8 hi unmasked", 32'(irq_hi), 1);
    check("R8 lo masked", 32'(irq_lo), 0);
    wr(3'd3, 32'd2);
    rd(3'd3, v); check("R7 clear lo", v, 1);
    wr(3'd3, 32'd0);
    rd(3'd3, v); check("R7 zero write", v, 1);
    wr(3'd4, 32'd3);
    rd(3'd4, v); check("R9 mask read", v, 3);
    check("R8 lo cleared", 32'(irq_lo), 0);
    check("R8 hi still", 32'(irq_hi), 1);
    wr(3'd3, 32'd1);
    rd(3'd3, v); check("R7 clear hi", v, 0);
    check("R8 hi gone", 32'(irq_hi), 0);
  endtask

  task automatic t_zero_period();
    logic [31:0] v;
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd1);
    for (int i = 0; i < 3; i++) begin
      check("R4 every cycle", 32'(expire), 1);
      @(negedge clk);
    end
    wr(3'd3, 32'd3);
    rd(3'd3, v); check("R7 set wins", v, 3);
    check("R8 both raised", {30'd0, irq_lo, irq_hi}, 3);
    wr(3'd0, 32'd0);
    check("R3 no pulse stopped", 32'(expire), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_interval();
    t_pending();
    t_zero_period();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule